// File: doc/BRIEF.md
# Keyed Flash Erase Control Register

This block is the erase and write-protect control register of a serial NOR flash controller. Software writes 32-bit words into it. One pattern lifts the write protection: the block then sends a write-enable command to the flash at once. A second pattern starts an erase of either a 64 kB sector or a 4 kB subsector. The second pattern is accepted only when its low bits hold a fixed key and the protection has already been lifted. The address in the word is a word address, not a byte address.

Device commands leave through an abstract command port. The block raises a one-cycle request that carries an 8-bit opcode and a 24-bit byte address, and the port answers with a one-cycle done pulse. After the erase command has been sent, the block keeps issuing status reads. It stops when a status read comes back with the device no longer busy. While any command sequence is running, the stall output is high and register writes are dropped. Readback shows a write-in-progress flag in bit 31 for the whole erase. When the erase finishes, the interrupt output is high for one cycle and write protection comes back on by itself.

Top module: `flash_erase_ctl`

## Requirements
- R1: After reset the block is idle. `cmd_req`, `irq` and `bus_stall` are low, readback is zero, and write protection is on (readback bit 30 = 0).
- R2: A write with bits [31:30] = 01 raises `cmd_req` in the next cycle with opcode 0x06. After `cmd_done`, readback bit 30 reads 1, which means write protection is off.
- R3: A write with bits [31:30] = 11, bit 28 = 0, bits [9:0] = 0x1BE and protection off raises `cmd_req` in the next cycle with opcode 0xD8. The address is the byte address of word address bits [21:0] with its low 16 bits cleared.
- R4: The same write with bit 28 = 1 sends opcode 0x20 instead. The address is the byte address with its low 12 bits cleared.
- R5: An erase write whose bits [9:0] are not 0x1BE is ignored. So is an erase write sent while protection is on, and any write whose bits [31:30] are neither 01 nor 11. An ignored write issues no request and leaves readback unchanged.
- R6: The `cmd_done` of the erase command is followed in the next cycle by a status-read request with opcode 0x05. Each status-read `cmd_done` that arrives with `dev_busy` = 1 is followed by another status-read request.
- R7: Readback bit 31 is 1 from the cycle after an erase is accepted until the operation completes.
- R8: The operation completes on a status-read `cmd_done` with `dev_busy` = 0. In the next cycle `irq` is high for exactly one cycle and readback bit 31 is 0.
- R9: `bus_stall` is high from the cycle after an accepted command until its sequence ends. Register writes made during that time are ignored.
- R10: Write protection turns back on when an erase completes. A later erase write is ignored until a new unlock write is made.
- R11: `cmd_req` is a single-cycle pulse. No new request is issued until `cmd_done` answers the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback: bit 31 erase in progress, bit 30 protection off |
| bus_stall | output | 1 | Block busy; bus requests must wait |
| cmd_req | output | 1 | One-cycle command request to the lower port |
| cmd_op | output | 8 | Command opcode |
| cmd_addr | output | 24 | Command byte address (zero for non-erase commands) |
| cmd_done | input | 1 | One-cycle completion from the lower port |
| dev_busy | input | 1 | Device busy flag returned with a status-read completion |
| irq | output | 1 | One-cycle erase-complete pulse |

## Verification
Each register write either produces a request on the command port in the very next cycle or produces none. A wrong decode or a wrong protection state therefore shows within one cycle as a missing request, an extra request, or a wrong opcode or address. A wrong sequencer state shows up at the next `cmd_done`: the following request is missing or has the wrong opcode, or `irq` and readback bit 31 change in the wrong cycle. Wrong protection state after completion is exposed on the readback port, and the next erase write then issues a request where none should appear.

// File: rtl/fec_pkg.sv
package fec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WEN_REQ,
    ST_WEN_WAIT,
    ST_ERS_REQ,
    ST_ERS_WAIT,
    ST_POL_REQ,
    ST_POL_WAIT
  } seq_state_t;

  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_SECT = 8'hD8;
  localparam logic [7:0] OPC_SUBS = 8'h20;
endpackage

// File: rtl/fec_decode.sv
module fec_decode #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 24,
  parameter int KEY_W   = 10,
  parameter logic [KEY_W-1:0] KEY = 10'h1BE,
  parameter int SECT_SH = 16,
  parameter int SUB_SH  = 12
) (
  input  logic [DATA_W-1:0] wdata,
  output logic              is_unlock,
  output logic              is_erase,
  output logic              is_sub,
  output logic [ADDR_W-1:0] byte_addr
);
  localparam int BIT_ERS = DATA_W - 1;
  localparam int BIT_UNL = DATA_W - 2;
  localparam int BIT_SUB = DATA_W - 4;
  localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << SECT_SH;
  localparam logic [ADDR_W-1:0] SUB_MASK  = {ADDR_W{1'b1}} << SUB_SH;

  logic [ADDR_W-1:0] full_addr;
  logic              key_ok;

  always_comb begin
    full_addr = {wdata[ADDR_W-3:0], 2'b00};
    key_ok    = (wdata[KEY_W-1:0] == KEY);
    is_unlock = ~wdata[BIT_ERS] & wdata[BIT_UNL];
    is_erase  = wdata[BIT_ERS] & wdata[BIT_UNL] & key_ok;
    is_sub    = wdata[BIT_SUB];
    byte_addr = is_sub ? (full_addr & SUB_MASK) : (full_addr & SECT_MASK);
  end
endmodule

// File: rtl/fec_seq.sv
module fec_seq
  import fec_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              is_unlock,
  input  logic              is_erase,
  input  logic              is_sub,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              cmd_done,
  input  logic              dev_busy,
  output logic              cmd_req,
  output logic [7:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              busy,
  output logic              wip,
  output logic              wp_off,
  output logic              irq
);
  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              sub_q;
  logic              wp_off_q, wp_off_d;
  logic              irq_q, irq_d;
  logic              cap_en;

  always_comb begin
    state_d  = state_q;
    wp_off_d = wp_off_q;
    irq_d    = 1'b0;
    cap_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (wr_en && is_unlock) begin
          state_d = ST_WEN_REQ;
        end else if (wr_en && is_erase && wp_off_q) begin
          state_d = ST_ERS_REQ;
          cap_en  = 1'b1;
        end
      end
      ST_WEN_REQ:  state_d = ST_WEN_WAIT;
      ST_WEN_WAIT: begin
        if (cmd_done) begin
          state_d  = ST_IDLE;
          wp_off_d = 1'b1;
        end
      end
      ST_ERS_REQ:  state_d = ST_ERS_WAIT;
      ST_ERS_WAIT: if (cmd_done) state_d = ST_POL_REQ;
      ST_POL_REQ:  state_d = ST_POL_WAIT;
      ST_POL_WAIT: begin
        if (cmd_done) begin
          if (dev_busy) begin
            state_d = ST_POL_REQ;
          end else begin
            state_d  = ST_IDLE;
            wp_off_d = 1'b0;
            irq_d    = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      wp_off_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      wp_off_q <= wp_off_d;
      irq_q    <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      sub_q  <= 1'b0;
    end else if (cap_en) begin
      addr_q <= byte_addr;
      sub_q  <= is_sub;
    end
  end

  always_comb begin
    cmd_req  = (state_q == ST_WEN_REQ) || (state_q == ST_ERS_REQ) ||
               (state_q == ST_POL_REQ);
    cmd_addr = (state_q == ST_ERS_REQ) ? addr_q : '0;
    case (state_q)
      ST_WEN_REQ: cmd_op = OPC_WREN;
      ST_ERS_REQ: cmd_op = sub_q ? OPC_SUBS : OPC_SECT;
      ST_POL_REQ: cmd_op = OPC_RDSR;
      default:    cmd_op = 8'h00;
    endcase
    busy   = (state_q != ST_IDLE);
    wip    = (state_q == ST_ERS_REQ) || (state_q == ST_ERS_WAIT) ||
             (state_q == ST_POL_REQ) || (state_q == ST_POL_WAIT);
    wp_off = wp_off_q;
    irq    = irq_q;
  end

  p_req_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |=> !cmd_req);
  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_poll_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERS_WAIT && cmd_done) |=> (cmd_req && cmd_op == OPC_RDSR));
  p_erase_unlocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && (cmd_op == OPC_SECT || cmd_op == OPC_SUBS)) |-> wp_off);
  p_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !wp_off);
  p_wip_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> irq);
endmodule

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24,
  parameter int KEY_W  = 10,
  parameter logic [KEY_W-1:0] KEY = 10'h1BE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              bus_stall,
  output logic              cmd_req,
  output logic [7:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_done,
  input  logic              dev_busy,
  output logic              irq
);
  logic              dec_unlock, dec_erase, dec_sub;
  logic [ADDR_W-1:0] dec_addr;
  logic              seq_busy, seq_wip, seq_wp_off;

  fec_decode #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY_W(KEY_W), .KEY(KEY),
    .SECT_SH(16), .SUB_SH(12)
  ) u_dec (
    .wdata(reg_wdata), .is_unlock(dec_unlock), .is_erase(dec_erase),
    .is_sub(dec_sub), .byte_addr(dec_addr)
  );

  fec_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr),
    .is_unlock(dec_unlock), .is_erase(dec_erase), .is_sub(dec_sub),
    .byte_addr(dec_addr), .cmd_done(cmd_done), .dev_busy(dev_busy),
    .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .busy(seq_busy), .wip(seq_wip), .wp_off(seq_wp_off), .irq(irq)
  );

  always_comb begin
    reg_rdata = {seq_wip, seq_wp_off, {(DATA_W-2){1'b0}}};
    bus_stall = seq_busy;
  end

  p_irq_clears_wip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !reg_rdata[DATA_W-1]);
  p_wip_stalls_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1] |-> bus_stall);
endmodule

// File: tb/tb_flash_erase_ctl.sv
module tb_flash_erase_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_stall, cmd_req, irq;
  logic [7:0]  cmd_op;
  logic [23:0] cmd_addr;
  logic        cmd_done = 1'b0;
  logic        dev_busy = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  flash_erase_ctl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bus_stall(bus_stall), .cmd_req(cmd_req),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_done(cmd_done),
    .dev_busy(dev_busy), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic pulse_done(input logic busy_flag);
    @(negedge clk);
    cmd_done = 1'b1;
    dev_busy = busy_flag;
    @(negedge clk);
    cmd_done = 1'b0;
    dev_busy = 1'b0;
  endtask

  task automatic unlock();
    wr(32'h4000_0000);
    chk(cmd_req === 1'b1, "R2 wren request", {31'd0, cmd_req}, 1);
    chk(cmd_op === 8'h06, "R2 wren opcode", {24'd0, cmd_op}, 32'h06);
    chk(bus_stall === 1'b1, "R9 stall during wren", {31'd0, bus_stall}, 1);
    @(negedge clk);
    chk(cmd_req === 1'b0, "R11 request single cycle", {31'd0, cmd_req}, 0);
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
    chk(reg_rdata === 32'h4000_0000, "R2 protection off readback", reg_rdata,
        32'h4000_0000);
    chk(bus_stall === 1'b0, "R9 stall released", {31'd0, bus_stall}, 0);
  endtask

  task automatic erase(input logic [31:0] d, input logic [7:0] eop,
                       input logic [23:0] eaddr, input int polls,
                       input bit try_write);
    wr(d);
    chk(cmd_req === 1'b1, "R3 erase request", {31'd0, cmd_req}, 1);
    chk(cmd_op === eop, "R4 erase opcode", {24'd0, cmd_op}, {24'd0, eop});
    chk(cmd_addr === eaddr, "R3 erase address", {8'd0, cmd_addr}, {8'd0, eaddr});
    chk(reg_rdata[31] === 1'b1, "R7 wip set", reg_rdata, 32'h8000_0000);
    @(negedge clk);
    chk(cmd_req === 1'b0, "R11 no request before done", {31'd0, cmd_req}, 0);
    if (try_write) begin
      reg_wr = 1'b1;
      reg_wdata = 32'h4000_0000;
      @(negedge clk);
      reg_wr = 1'b0;
      reg_wdata = '0;
      chk(cmd_req === 1'b0, "R9 write while busy ignored", {31'd0, cmd_req}, 0);
      chk(bus_stall === 1'b1, "R9 stall while busy", {31'd0, bus_stall}, 1);
    end
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
    chk(cmd_req === 1'b1 && cmd_op === 8'h05, "R6 first poll",
        {24'd0, cmd_op}, 32'h05);
    for (int i = 0; i < polls; i++) begin
      pulse_done(1'b1);
      chk(cmd_req === 1'b1 && cmd_op === 8'h05, "R6 repeated poll",
          {24'd0, cmd_op}, 32'h05);
      chk(reg_rdata[31] === 1'b1 && irq === 1'b0, "R7 wip held",
          reg_rdata, 32'h8000_0000);
    end
    pulse_done(1'b0);
    chk(irq === 1'b1, "R8 irq at completion", {31'd0, irq}, 1);
    chk(reg_rdata === 32'h0, "R10 wip clear and protection on", reg_rdata, 0);
    @(negedge clk);
    chk(irq === 1'b0, "R8 irq one cycle", {31'd0, irq}, 0);
    chk(bus_stall === 1'b0, "R9 stall off after erase", {31'd0, bus_stall}, 0);
  endtask

  task automatic expect_ignored(input logic [31:0] d, input logic [31:0] rb,
                                input string tag);
    wr(d);
    chk(cmd_req === 1'b0, tag, {31'd0, cmd_req}, 0);
    chk(reg_rdata === rb && bus_stall === 1'b0, tag, reg_rdata, rb);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(reg_rdata === 32'h0, "R1 reset readback", reg_rdata, 0);
    chk(cmd_req === 1'b0 && irq === 1'b0 && bus_stall === 1'b0,
        "R1 reset outputs", {29'd0, cmd_req, irq, bus_stall}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    expect_ignored(32'hC000_01BE, 32'h0, "R5 erase while protected");
    expect_ignored(32'hD000_41BE, 32'h0, "R5 subsector while protected");

    unlock();
    for (int k = 0; k < 1024; k++) begin
      if (k != 32'h1BE)
        expect_ignored(32'hC000_0000 | k, 32'h4000_0000, "R5 bad key");
    end
    expect_ignored(32'h8000_01BE, 32'h4000_0000, "R5 bit30 clear");
    expect_ignored(32'h0000_01BE, 32'h4000_0000, "R5 plain write");

    for (int s = 0; s < 256; s++) begin
      unlock();
      erase(32'hC000_01BE | (s << 14) | ((s % 16) << 10), 8'hD8,
            24'(s << 16), s % 3, (s % 17) == 0);
    end

    for (int u = 0; u < 4096; u += 5) begin
      unlock();
      erase(32'hD000_01BE | (u << 10), 8'h20, 24'(u << 12), u % 4, 1'b0);
    end

    expect_ignored(32'hC000_01BE, 32'h0, "R10 rearmed blocks erase");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule